// File: doc/BRIEF.md
# Framebuffer Scanout Address Generator

This block walks a linear framebuffer one line at a time and emits the burst read requests needed to fetch a whole frame. Software supplies the start address of the first line, the number of bytes to read from each line, the byte distance between the starts of successive lines, and the number of lines minus one. Each line is split into bursts no longer than a programmable maximum of up to 16 beats. The last burst of a line covers only the beats that remain.

Requests go out on a valid/acknowledge handshake. A completion pulse from the memory side retires one request. A programmable cap bounds how many requests may be in flight at once. A frame-start pulse samples the whole configuration and restarts the walk at the base address. Configuration changes made during a frame take effect only at the next pulse. After the final line the generator stays idle until the next pulse arrives.

Top module: `scanout_addr_gen`

## Requirements
- R1: After reset no request is presented, `busy` is low and nothing is counted as outstanding.
- R2: On a `frame_start` pulse, the cycle after the pulse shows `busy` high and `req_addr` equal to `cfg_base` as sampled in the pulse cycle.
- R3: Within a line, bursts follow one another at increasing addresses, each starting where the previous one ended. Each burst carries min(remaining beats, burst limit) beats. A `cfg_burst_max` of 1 to 16 is the burst limit; 0 or any value above 16 selects 16.
- R4: `cfg_line_len` is in bytes and is a multiple of BEAT_BYTES. A frame fetches `cfg_lines_m1`+1 lines, and line n starts at base + n × `cfg_pitch`.
- R5: Once the last burst of the last line is accepted, `busy` falls and `req_valid` stays low until the next `frame_start`.
- R6: Each accepted request raises the outstanding count by one, and each `rsp_done` pulse lowers it by one. No request is presented while the count equals the sampled `cfg_max_out`.
- R7: The configuration inputs are sampled only in the `frame_start` cycle. A change during a frame leaves the current frame's requests unchanged and applies to the next frame.
- R8: A `frame_start` during a frame abandons the rest of that frame and restarts at the newly sampled base. No request is accepted in the pulse cycle.
- R9: A presented request holds `req_valid`, `req_addr` and `req_beats` steady until it is acknowledged.
- R10: A line length below one beat issues no request, and `busy` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_start | input | 1 | Start-of-frame pulse; samples configuration |
| cfg_base | input | ADDR_W | Byte address of the first line |
| cfg_line_len | input | LEN_W | Bytes fetched per line |
| cfg_pitch | input | LEN_W | Byte step between line starts |
| cfg_lines_m1 | input | CNT_W | Line count minus one |
| cfg_burst_max | input | 5 | Burst limit in beats (0 or >16 means 16) |
| cfg_max_out | input | OUT_W | Outstanding request cap |
| req_valid | output | 1 | Request presented |
| req_ack | input | 1 | Request accepted this cycle |
| req_addr | output | ADDR_W | Byte address of the burst |
| req_beats | output | 5 | Burst length in beats (1 to 16) |
| rsp_done | input | 1 | One request completed |
| busy | output | 1 | Frame walk in progress |

## Verification
The bench builds the block with BEAT_BYTES of 4, LEN_W of 12, CNT_W of 8 and OUT_W of 3. With these sizes, lines that need several bursts, shortened final bursts and a cap of two are all reached in a few hundred cycles. A narrow burst limit of 4 sets the split boundary apart from the 16-beat default. Holding completions back lets the cap fill, so the stall and the single-slot release can be seen at the ports.

// File: rtl/scanout_addr_gen.sv
module scanout_addr_gen #(
  parameter int ADDR_W     = 32,
  parameter int LEN_W      = 16,
  parameter int CNT_W      = 12,
  parameter int BEAT_BYTES = 16,
  parameter int OUT_W      = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_start,
  input  logic [ADDR_W-1:0] cfg_base,
  input  logic [LEN_W-1:0]  cfg_line_len,
  input  logic [LEN_W-1:0]  cfg_pitch,
  input  logic [CNT_W-1:0]  cfg_lines_m1,
  input  logic [4:0]        cfg_burst_max,
  input  logic [OUT_W-1:0]  cfg_max_out,
  output logic              req_valid,
  input  logic              req_ack,
  output logic [ADDR_W-1:0] req_addr,
  output logic [4:0]        req_beats,
  input  logic              rsp_done,
  output logic              busy
);
  localparam int BEAT_LG = $clog2(BEAT_BYTES);

  logic              busy_q;
  logic [ADDR_W-1:0] cur_addr, line_addr;
  logic [LEN_W-1:0]  rem, len_beats_q, pitch_q;
  logic [CNT_W-1:0]  line_idx, lines_q;
  logic [4:0]        bmax_q;
  logic [OUT_W-1:0]  max_q, out_cnt;

  wire [LEN_W-1:0] cfg_beats  = cfg_line_len >> BEAT_LG;
  wire [4:0]       cfg_bmax   = (cfg_burst_max == 5'd0 || cfg_burst_max > 5'd16) ? 5'd16 : cfg_burst_max;
  wire [4:0]       beats      = (rem >= LEN_W'(bmax_q)) ? bmax_q : rem[4:0];
  wire             last_burst = (rem == LEN_W'(beats));
  wire             last_line  = (line_idx == lines_q);
  wire             issue      = req_valid && req_ack;
  wire             done       = rsp_done && (out_cnt != '0);

  assign req_valid = busy_q && !frame_start && (out_cnt < max_q);
  assign req_addr  = cur_addr;
  assign req_beats = beats;
  assign busy      = busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q      <= 1'b0;
      cur_addr    <= '0;
      line_addr   <= '0;
      rem         <= '0;
      len_beats_q <= '0;
      pitch_q     <= '0;
      line_idx    <= '0;
      lines_q     <= '0;
      bmax_q      <= 5'd16;
      max_q       <= '0;
    end else if (frame_start) begin
      busy_q      <= (cfg_beats != '0);
      cur_addr    <= cfg_base;
      line_addr   <= cfg_base;
      rem         <= cfg_beats;
      len_beats_q <= cfg_beats;
      pitch_q     <= cfg_pitch;
      line_idx    <= '0;
      lines_q     <= cfg_lines_m1;
      bmax_q      <= cfg_bmax;
      max_q       <= cfg_max_out;
    end else if (issue) begin
      if (last_burst) begin
        if (last_line) begin
          busy_q <= 1'b0;
        end else begin
          line_addr <= line_addr + ADDR_W'(pitch_q);
          cur_addr  <= line_addr + ADDR_W'(pitch_q);
          rem       <= len_beats_q;
          line_idx  <= line_idx + 1'b1;
        end
      end else begin
        cur_addr <= cur_addr + (ADDR_W'(beats) << BEAT_LG);
        rem      <= rem - LEN_W'(beats);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                out_cnt <= '0;
    else if (issue && !done)   out_cnt <= out_cnt + 1'b1;
    else if (!issue && done)   out_cnt <= out_cnt - 1'b1;
  end

  AST_RESET_QUIET: assert property (@(posedge clk) !rst_n |=> !busy && !req_valid); // R1
  AST_FRAME_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start && cfg_beats != '0) |=> busy && req_addr == $past(cfg_base)); // R2
  AST_BEATS_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (req_beats != 5'd0 && req_beats <= bmax_q)); // R3
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !req_valid); // R5
  AST_NO_OVER_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> out_cnt < max_q); // R6
  AST_HOLD_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ack && !frame_start) |=> (frame_start || (req_valid && $stable(req_addr) && $stable(req_beats)))); // R9
endmodule

// File: tb/tb_scanout_addr_gen.sv
module tb_scanout_addr_gen;
  localparam int AW = 32, LW = 12, CW = 8, BB = 4, OW = 3;

  logic          clk = 1'b0, rst_n = 1'b0, frame_start = 1'b0;
  logic [AW-1:0] cfg_base = '0;
  logic [LW-1:0] cfg_line_len = '0, cfg_pitch = '0;
  logic [CW-1:0] cfg_lines_m1 = '0;
  logic [4:0]    cfg_burst_max = '0;
  logic [OW-1:0] cfg_max_out = 3'd7;
  logic          req_valid, req_ack = 1'b1, rsp_done = 1'b0, busy;
  logic [AW-1:0] req_addr;
  logic [4:0]    req_beats;

  scanout_addr_gen #(.ADDR_W(AW), .LEN_W(LW), .CNT_W(CW), .BEAT_BYTES(BB), .OUT_W(OW)) dut (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .cfg_base(cfg_base),
    .cfg_line_len(cfg_line_len), .cfg_pitch(cfg_pitch), .cfg_lines_m1(cfg_lines_m1),
    .cfg_burst_max(cfg_burst_max), .cfg_max_out(cfg_max_out), .req_valid(req_valid),
    .req_ack(req_ack), .req_addr(req_addr), .req_beats(req_beats), .rsp_done(rsp_done),
    .busy(busy));

  always #5 clk = ~clk;

  int tests = 0, fails = 0, cycles = 0;
  int nlog = 0, out_model = 0;
  bit rsp_auto = 1'b1, rsp_force = 1'b0;
  logic [AW-1:0] log_addr [0:255];
  int            log_beats [0:255];

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected < 100000", cycles);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  always @(negedge clk) begin
    #2;
    if ((rsp_auto || rsp_force) && out_model > 0) begin
      rsp_done = 1'b1;
      out_model--;
    end else rsp_done = 1'b0;
    if (req_valid && req_ack) begin
      if (nlog < 256) begin
        log_addr[nlog]  = req_addr;
        log_beats[nlog] = int'(req_beats);
      end
      nlog++;
      out_model++;
    end
  end

  task automatic chk(input string req, input longint act, input longint exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic start_frame(input logic [AW-1:0] b, input int len, input int pitch,
                             input int lm1, input int bm, input int mo);
    @(negedge clk);
    cfg_base = b; cfg_line_len = LW'(len); cfg_pitch = LW'(pitch);
    cfg_lines_m1 = CW'(lm1); cfg_burst_max = 5'(bm); cfg_max_out = OW'(mo);
    frame_start = 1'b1;
    nlog = 0;
    @(negedge clk);
    frame_start = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 3000 && busy; i++) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic check_log(input string req, input logic [AW-1:0] b, input int len,
                           input int pitch, input int lm1, input int bm);
    int idx = 0;
    int lim = (bm == 0 || bm > 16) ? 16 : bm;
    for (int l = 0; l <= lm1; l++) begin
      int rem = len / BB;
      logic [AW-1:0] a = b + AW'(l * pitch);
      while (rem > 0) begin
        int n = (rem < lim) ? rem : lim;
        if (idx < nlog) begin
          chk({req, " addr"}, log_addr[idx], a);
          chk({req, " beats"}, log_beats[idx], n);
        end
        a = a + AW'(n * BB);
        rem -= n;
        idx++;
      end
    end
    chk({req, " burst count"}, nlog, idx);
  endtask

  task automatic t_reset();
    repeat (2) @(negedge clk);
    chk("R1 valid", req_valid, 0);
    chk("R1 busy", busy, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 valid after release", req_valid, 0);
  endtask

  task automatic t_basic();
    start_frame(32'h1000, 40, 64, 2, 16, 7);
    chk("R2 busy", busy, 1);
    chk("R2 first addr", req_addr, 32'h1000);
    wait_idle();
    check_log("R4 three lines", 32'h1000, 40, 64, 2, 16);
  endtask

  task automatic t_split();
    start_frame(32'h2000, 160, 256, 1, 0, 7);
    wait_idle();
    check_log("R3 split default limit", 32'h2000, 160, 256, 1, 0);
    start_frame(32'h3000, 40, 48, 3, 4, 7);
    wait_idle();
    check_log("R3 limit four", 32'h3000, 40, 48, 3, 4);
    start_frame(32'h3400, 24, 32, 0, 20, 7);
    wait_idle();
    check_log("R3 oversize limit", 32'h3400, 24, 32, 0, 20);
  endtask

  task automatic t_idle();
    start_frame(32'h500, 8, 8, 0, 16, 7);
    wait_idle();
    chk("R4 single line count", nlog, 1);
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (req_valid || busy) begin
        chk("R5 idle quiet", 1, 0);
        break;
      end
    end
    chk("R5 no extra bursts", nlog, 1);
    chk("R5 busy low", busy, 0);
  endtask

  task automatic t_cap();
    rsp_auto = 1'b0;
    start_frame(32'h4000, 64, 64, 0, 4, 2);
    repeat (20) @(negedge clk);
    chk("R6 issued up to cap", nlog, 2);
    chk("R6 stalled at cap", req_valid, 0);
    rsp_force = 1'b1;
    @(negedge clk);
    rsp_force = 1'b0;
    repeat (6) @(negedge clk);
    chk("R6 one slot released", nlog, 3);
    rsp_auto = 1'b1;
    wait_idle();
    check_log("R6 frame after release", 32'h4000, 64, 64, 0, 4);
  endtask

  task automatic t_midframe_cfg();
    start_frame(32'h8000, 64, 128, 3, 4, 7);
    repeat (3) @(negedge clk);
    cfg_base = 32'h9000; cfg_line_len = 12'd16; cfg_burst_max = 5'd2;
    wait_idle();
    check_log("R7 old frame kept", 32'h8000, 64, 128, 3, 4);
    start_frame(32'h9000, 16, 128, 1, 2, 7);
    wait_idle();
    check_log("R7 new frame applied", 32'h9000, 16, 128, 1, 2);
  endtask

  task automatic t_restart();
    start_frame(32'hA000, 256, 256, 9, 4, 7);
    repeat (6) @(negedge clk);
    chk("R8 busy before restart", busy, 1);
    start_frame(32'hC000, 32, 64, 1, 16, 7);
    wait_idle();
    check_log("R8 restarted frame", 32'hC000, 32, 64, 1, 16);
  endtask

  task automatic t_hold();
    req_ack = 1'b0;
    start_frame(32'hD000, 32, 32, 0, 4, 7);
    repeat (5) @(negedge clk);
    chk("R9 valid held", req_valid, 1);
    chk("R9 addr held", req_addr, 32'hD000);
    chk("R9 beats held", req_beats, 4);
    chk("R9 nothing accepted", nlog, 0);
    req_ack = 1'b1;
    wait_idle();
    check_log("R9 after ack", 32'hD000, 32, 32, 0, 4);
  endtask

  task automatic t_zero();
    start_frame(32'hE000, 2, 8, 3, 16, 7);
    repeat (5) @(negedge clk);
    chk("R10 busy low", busy, 0);
    chk("R10 no requests", nlog, 0);
  endtask

  initial begin
    t_reset();
    t_basic();
    t_split();
    t_idle();
    t_cap();
    t_midframe_cfg();
    t_restart();
    t_hold();
    t_zero();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule